// File: doc/BRIEF.md
# Tagged Page Ownership and Key Selector

This block guards physical memory shared among several virtual machines. Every physical page has one table entry. The entry holds three things: the address-space ID that owns the page, the guest page number the page is bound to, and a validated flag. ID 0 is the host (hypervisor). Every other ID is a guest, and each ID has its own encryption key slot.

On every command the block reads the entry of the addressed physical page and decides the outcome:
- An access from the owning guest is granted only when the guest page number matches and the page has been validated. On a grant the block outputs the key-slot index for the memory encryption engine.
- A host access to a guest page gets no plaintext. The block reports it as encrypted-only.
- Only the host may rebind a page to a new owner or guest page. Any rebind clears the validated flag, so the guest has to validate the page again before it can use it. A page swapped behind the guest's back therefore faults before the guest reads it.

A response appears exactly one clock after its command. Key generation and the cipher are outside this block.

Top module: `page_owner_guard`

## Requirements
- R1: After reset every page is owned by ID 0 with guest page 0 and its validated flag clear. Every response output is low until the first command.
- R2: A command with `cmd_valid` high and an operation code of 0 (access), 1 (rebind) or 2 (validate) gives `rsp_valid` high in the next cycle. Operation code 3, or `cmd_valid` low, gives `rsp_valid` low and all other response outputs low.
- R3: An access from a nonzero ID is granted when that ID equals the page owner, the guest page matches and the page is validated. On that grant `rsp_key_slot` equals the requester ID.
- R4: An access from a nonzero ID that differs from the page owner faults with cause 1 (owner mismatch).
- R5: An access from ID 0 to a page owned by ID 0 is granted with key slot 0. An access from ID 0 to a guest-owned page is neither granted nor faulted, and `rsp_enc_only` is high.
- R6: A rebind from ID 0 writes the new owner and guest page and clears the validated flag, with no grant and no fault. A rebind from a nonzero ID faults with cause 1 and leaves the entry unchanged.
- R7: An owner-matching guest access whose guest page matches but whose validated flag is clear faults with cause 2 (remap).
- R8: A guest access whose owner matches but whose guest page differs faults with cause 3. The causes are ranked owner (1) first, then guest page (3), then validation (2).
- R9: A validate command sets the validated flag only when the requester equals the owner and the guest page matches. Otherwise it faults with cause 1 or 3 under the same ranking and leaves the flag unchanged.
- R10: `rsp_key_slot` is zero whenever `rsp_grant` is low.
- R11: `rsp_grant`, `rsp_fault` and `rsp_enc_only` are never high together in pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 access, 1 rebind, 2 validate, 3 idle |
| cmd_id | input | ID_W (4) | Requester address-space ID, 0 is the host |
| cmd_ppage | input | IDX_W (4) | Physical page index |
| cmd_gpage | input | GP_W (8) | Guest page number (expected, or new on rebind) |
| cmd_new_owner | input | ID_W (4) | New owner ID for a rebind |
| rsp_valid | output | 1 | Response for the previous cycle's command |
| rsp_grant | output | 1 | Access or plaintext use allowed |
| rsp_fault | output | 1 | Command refused |
| rsp_cause | output | 2 | 0 none, 1 owner, 2 remap, 3 guest page |
| rsp_enc_only | output | 1 | Host sees ciphertext only |
| rsp_key_slot | output | ID_W (4) | Key slot on a grant, zero otherwise |

## Verification
A corrupted owner field shows up on the very next access to that page, one cycle later, as an owner fault or a wrong key slot. A validated flag that a rebind failed to clear shows up as a grant where a remap fault belongs. Because a response follows its command by exactly one clock, the bench checks every entry the first time it is read after a change.

// File: rtl/pog_pkg.sv
package pog_pkg;
    typedef enum logic [1:0] {
        OP_ACCESS   = 2'd0,
        OP_REBIND   = 2'd1,
        OP_VALIDATE = 2'd2,
        OP_IDLE     = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_OWNER  = 2'd1,
        CAUSE_REMAP  = 2'd2,
        CAUSE_GPAGE  = 2'd3
    } cause_e;
endpackage

// File: rtl/pog_table.sv
module pog_table #(
    parameter int NUM_PAGES = 16,
    parameter int ID_W      = 4,
    parameter int GP_W      = 8,
    localparam int IDX_W    = $clog2(NUM_PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             upd_en,
    input  logic             val_en,
    input  logic [ID_W-1:0]  new_owner,
    input  logic [GP_W-1:0]  new_gpage,
    output logic [ID_W-1:0]  rd_owner,
    output logic [GP_W-1:0]  rd_gpage,
    output logic             rd_vld
);
    typedef struct packed {
        logic [NUM_PAGES-1:0][ID_W-1:0] owner;
        logic [NUM_PAGES-1:0][GP_W-1:0] gpage;
        logic [NUM_PAGES-1:0]           vld;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (upd_en) begin
            tbl_d.owner[idx] = new_owner;
            tbl_d.gpage[idx] = new_gpage;
            tbl_d.vld[idx]   = 1'b0;
        end else if (val_en) begin
            tbl_d.vld[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign rd_owner = tbl_q.owner[idx];
    assign rd_gpage = tbl_q.gpage[idx];
    assign rd_vld   = tbl_q.vld[idx];

    a_r6_rebind_clears: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (!tbl_q.vld[$past(idx)] && tbl_q.owner[$past(idx)] == $past(new_owner)
                    && tbl_q.gpage[$past(idx)] == $past(new_gpage)));

    a_r9_validate_sets: assert property (@(posedge clk) disable iff (!rst_n)
        val_en |=> tbl_q.vld[$past(idx)]);

    a_r6_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_en && val_en));
endmodule

// File: rtl/pog_check.sv
module pog_check
    import pog_pkg::*;
#(
    parameter int ID_W = 4,
    parameter int GP_W = 8
) (
    input  op_e             op,
    input  logic [ID_W-1:0] req_id,
    input  logic [GP_W-1:0] req_gpage,
    input  logic [ID_W-1:0] own,
    input  logic [GP_W-1:0] gp,
    input  logic            vld,
    output logic            rsp_vld,
    output logic            grant,
    output logic            fault,
    output cause_e          cause,
    output logic            enc_only,
    output logic [ID_W-1:0] key_slot,
    output logic            upd_en,
    output logic            val_en
);
    always_comb begin
        rsp_vld  = (op != OP_IDLE);
        grant    = 1'b0;
        fault    = 1'b0;
        cause    = CAUSE_NONE;
        enc_only = 1'b0;
        key_slot = '0;
        upd_en   = 1'b0;
        val_en   = 1'b0;
        unique case (op)
            OP_ACCESS: begin
                if (req_id == '0) begin
                    if (own == '0) grant = 1'b1;
                    else           enc_only = 1'b1;
                end else if (own != req_id) begin
                    fault = 1'b1;
                    cause = CAUSE_OWNER;
                end else if (gp != req_gpage) begin
                    fault = 1'b1;
                    cause = CAUSE_GPAGE;
                end else if (!vld) begin
                    fault = 1'b1;
                    cause = CAUSE_REMAP;
                end else begin
                    grant    = 1'b1;
                    key_slot = own;
                end
            end
            OP_REBIND: begin
                if (req_id == '0) begin
                    upd_en = 1'b1;
                end else begin
                    fault = 1'b1;
                    cause = CAUSE_OWNER;
                end
            end
            OP_VALIDATE: begin
                if (own != req_id) begin
                    fault = 1'b1;
                    cause = CAUSE_OWNER;
                end else if (gp != req_gpage) begin
                    fault = 1'b1;
                    cause = CAUSE_GPAGE;
                end else begin
                    val_en = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/page_owner_guard.sv
module page_owner_guard
    import pog_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    parameter int ID_W      = 4,
    parameter int GP_W      = 8,
    localparam int IDX_W    = $clog2(NUM_PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [ID_W-1:0]  cmd_id,
    input  logic [IDX_W-1:0] cmd_ppage,
    input  logic [GP_W-1:0]  cmd_gpage,
    input  logic [ID_W-1:0]  cmd_new_owner,
    output logic             rsp_valid,
    output logic             rsp_grant,
    output logic             rsp_fault,
    output logic [1:0]       rsp_cause,
    output logic             rsp_enc_only,
    output logic [ID_W-1:0]  rsp_key_slot
);
    typedef struct packed {
        logic            valid;
        logic            grant;
        logic            fault;
        logic [1:0]      cause;
        logic            enc_only;
        logic [ID_W-1:0] key;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    op_e             op_eff;
    logic [ID_W-1:0] tb_owner;
    logic [GP_W-1:0] tb_gpage;
    logic            tb_vld;
    logic            ck_vld, ck_grant, ck_fault, ck_enc, ck_upd, ck_val;
    cause_e          ck_cause;
    logic [ID_W-1:0] ck_key;

    assign op_eff = cmd_valid ? op_e'(cmd_op) : OP_IDLE;

    pog_table #(.NUM_PAGES(NUM_PAGES), .ID_W(ID_W), .GP_W(GP_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (cmd_ppage),
        .upd_en    (ck_upd),
        .val_en    (ck_val),
        .new_owner (cmd_new_owner),
        .new_gpage (cmd_gpage),
        .rd_owner  (tb_owner),
        .rd_gpage  (tb_gpage),
        .rd_vld    (tb_vld)
    );

    pog_check #(.ID_W(ID_W), .GP_W(GP_W)) u_check (
        .op        (op_eff),
        .req_id    (cmd_id),
        .req_gpage (cmd_gpage),
        .own       (tb_owner),
        .gp        (tb_gpage),
        .vld       (tb_vld),
        .rsp_vld   (ck_vld),
        .grant     (ck_grant),
        .fault     (ck_fault),
        .cause     (ck_cause),
        .enc_only  (ck_enc),
        .key_slot  (ck_key),
        .upd_en    (ck_upd),
        .val_en    (ck_val)
    );

    always_comb begin
        rsp_d.valid    = ck_vld;
        rsp_d.grant    = ck_grant;
        rsp_d.fault    = ck_fault;
        rsp_d.cause    = ck_cause;
        rsp_d.enc_only = ck_enc;
        rsp_d.key      = ck_key;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_grant    = rsp_q.grant;
    assign rsp_fault    = rsp_q.fault;
    assign rsp_cause    = rsp_q.cause;
    assign rsp_enc_only = rsp_q.enc_only;
    assign rsp_key_slot = rsp_q.key;

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != 2'd3) |=> rsp_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_grant && !rsp_fault && !rsp_enc_only));

    a_r3_key_is_requester: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> rsp_key_slot == $past(cmd_id));

    a_r5_enc_only_host: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_enc_only |-> $past(cmd_id) == '0);

    a_r10_key_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_grant |-> rsp_key_slot == '0);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_grant, rsp_fault, rsp_enc_only}) <= 1);

    a_r6_rebind_host_only: assert property (@(posedge clk) disable iff (!rst_n)
        ck_upd |-> cmd_id == '0);
endmodule

// File: tb/page_owner_guard_bench.sv
`timescale 1ns/1ps
module page_owner_guard_bench;
    localparam int NP = 16;
    localparam int IW = 4;
    localparam int GW = 8;
    localparam int XW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [IW-1:0] cmd_id = '0;
    logic [XW-1:0] cmd_ppage = '0;
    logic [GW-1:0] cmd_gpage = '0;
    logic [IW-1:0] cmd_new_owner = '0;
    logic          rsp_valid, rsp_grant, rsp_fault, rsp_enc_only;
    logic [1:0]    rsp_cause;
    logic [IW-1:0] rsp_key_slot;

    int n_checks = 0;
    int n_fail   = 0;
    int m_owner [NP];
    int m_gp    [NP];
    bit m_vld   [NP];

    always #2.5 clk = ~clk;

    page_owner_guard #(.NUM_PAGES(NP), .ID_W(IW), .GP_W(GW)) u_page_owner_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_id(cmd_id), .cmd_ppage(cmd_ppage), .cmd_gpage(cmd_gpage),
        .cmd_new_owner(cmd_new_owner), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_enc_only(rsp_enc_only),
        .rsp_key_slot(rsp_key_slot)
    );

    function automatic logic [9:0] pack(bit v, bit g, bit f, int c, bit e, int k);
        return {v, g, f, 2'(c), e, 4'(k)};
    endfunction

    task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (v,g,f,cause,enc,key)", tag, act, exp);
        end
    endtask

    // Drive one command after a negedge, predict, then check at the next negedge.
    task automatic issue(bit v, int op, int id, int pp, int gp, int no);
        bit eg = 0, ef = 0, ee = 0;
        int ec = 0, ek = 0;
        string tag = "R2";
        bit ev = v && (op != 3);
        cmd_valid = v; cmd_op = 2'(op); cmd_id = IW'(id); cmd_ppage = XW'(pp);
        cmd_gpage = GW'(gp); cmd_new_owner = IW'(no);
        if (ev) begin
            case (op)
                0: begin
                    if (id == 0) begin
                        tag = "R5";
                        if (m_owner[pp] == 0) eg = 1; else ee = 1;
                    end else if (m_owner[pp] != id) begin ef = 1; ec = 1; tag = "R4"; end
                    else if (m_gp[pp] != gp) begin ef = 1; ec = 3; tag = "R8"; end
                    else if (!m_vld[pp]) begin ef = 1; ec = 2; tag = "R7"; end
                    else begin eg = 1; ek = id; tag = "R3"; end
                end
                1: begin
                    tag = "R6";
                    if (id == 0) begin m_owner[pp] = no; m_gp[pp] = gp; m_vld[pp] = 0; end
                    else begin ef = 1; ec = 1; end
                end
                default: begin
                    tag = "R9";
                    if (m_owner[pp] != id) begin ef = 1; ec = 1; end
                    else if (m_gp[pp] != gp) begin ef = 1; ec = 3; end
                    else m_vld[pp] = 1;
                end
            endcase
        end
        @(negedge clk);
        check(tag, {rsp_valid, rsp_grant, rsp_fault, rsp_cause, rsp_enc_only, rsp_key_slot},
              pack(ev, eg, ef, ec, ee, ek));
        cmd_valid = 0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) begin m_owner[i] = 0; m_gp[i] = 0; m_vld[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check("R1", {rsp_valid, rsp_grant, rsp_fault, rsp_cause, rsp_enc_only, rsp_key_slot}, '0);
        issue(1, 0, 0, 3, 0, 0);        // R1/R5 host owns page, grant slot 0
        issue(1, 0, 2, 3, 0, 0);        // R4 guest on host page
        issue(1, 1, 1, 3, 8'h15, 2);    // R6 rebind from guest refused
        issue(1, 0, 0, 3, 0, 0);        // R6 entry unchanged
        issue(1, 1, 0, 3, 8'h15, 2);    // R6 host rebind
        issue(1, 0, 2, 3, 8'h15, 0);    // R7 not yet validated
        issue(1, 2, 2, 3, 8'h16, 0);    // R9 wrong guest page
        issue(1, 2, 3, 3, 8'h15, 0);    // R9 wrong owner
        issue(1, 0, 2, 3, 8'h15, 0);    // R9 flag still clear -> remap
        issue(1, 2, 2, 3, 8'h15, 0);    // R9 validate ok
        issue(1, 0, 2, 3, 8'h15, 0);    // R3 grant slot 2
        issue(1, 0, 0, 3, 0, 0);        // R5 encrypted-only
        issue(1, 0, 2, 3, 8'h99, 0);    // R8 guest page mismatch
        issue(1, 0, 5, 3, 8'h99, 0);    // R8 owner ranks first
        issue(1, 1, 0, 3, 8'h20, 2);    // R6 silent remap
        issue(1, 0, 2, 3, 8'h20, 0);    // R7 remap faults
        issue(1, 3, 2, 3, 8'h20, 0);    // R2 idle op
        issue(0, 0, 2, 3, 8'h20, 0);    // R2 no valid
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 3);
            int id = $urandom_range(0, 3);
            if (op == 1 && $urandom_range(0, 3) != 0) id = 0;
            issue($urandom_range(0, 9) != 0, op, id, $urandom_range(0, 7),
                  $urandom_range(0, 3), $urandom_range(0, 3));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule